// File: doc/BRIEF.md
# Sorted Performance State Table Builder

This block assembles a table of up to sixteen performance states from a byte stream. Each state arrives as two bytes, a frequency code followed by a voltage code. For every state the block looks up a clock multiplier (held in tenths) and multiplies it by the bus frequency to get the state's core frequency in kHz. It then files the state into a table that is kept ordered from fastest to slowest. Ordering is done by insertion: existing entries move down one slot per clock until the new entry's place is found.

Two options shape the table. A narrow mode decodes 5-bit codes through an irregular multiplier table. A wide mode decodes 6-bit codes through a linear one. A drop option discards every state whose multiplier is a half step, and those states are not counted.

Once the table is built, a combinational match port searches it for a given (frequency code, voltage code) pair. A read port returns any slot by index.

Top module: `pstate_table`

## Requirements
- R1: After reset or a one-cycle `build_start` pulse, `state_count` is 0 and `in_ready` is 1. Every slot then reads back frequency code 0, voltage code 0 and frequency 24'hFFFFFF, which is the unknown marker.
- R2: Bytes accepted while `in_valid` and `in_ready` are both high alternate. The first byte of a pair is the frequency code and the second is the voltage code. The stored frequency is 100 × multiplier_tenths × `fsb_mhz` kHz, using the `fsb_mhz` value present when the second byte is accepted.
- R3: With `wide_fid`=0, the low 5 bits of the code select the multiplier, in tenths:
  - codes 0..3 give 110, 115, 120, 125;
  - codes 4..15 give 50 + 5·(code−4);
  - codes 16..29 give 30, 190, 40, 200, 130, 135, 140, 210, 150, 225, 160, 165, 170, 180;
  - codes 30 and 31 give 0.
- R4: With `wide_fid`=1, the multiplier in tenths is 40 + 5·c, where c is the low 6 bits of the code.
- R5: Kept states sit in slots 0..`state_count`−1 in non-increasing frequency order. A state whose frequency equals that of states already present is placed after them.
- R6: A kept state that passes over k existing entries holds `in_ready` low for exactly k+1 cycles after its second byte is accepted. `state_count` rises by one in the last of those cycles.
- R7: With `half_drop`=1, a state whose multiplier in tenths ends in 5 is discarded. It does not change `state_count` or the table, and `in_ready` stays high. With `half_drop`=0 such states are kept.
- R8: When the table already holds 16 states, further pairs are discarded and `state_count` stays at 16.
- R9: The match port reports `lk_hit`=1 and returns the lowest slot index below `state_count` whose codes equal `lk_fid` and `lk_vid`, together with that slot's frequency. With no match it reports `lk_hit`=0, index 0 and the unknown marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| build_start | input | 1 | Empties the table for a new build |
| half_drop | input | 1 | Discard half-step multiplier states |
| wide_fid | input | 1 | Select linear 6-bit multiplier decode |
| fsb_mhz | input | 8 | Bus frequency in MHz |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Input byte: frequency code, then voltage code |
| state_count | output | 5 | Number of kept states |
| rd_idx | input | 4 | Slot to read |
| rd_fid | output | 8 | Frequency code of read slot |
| rd_vid | output | 8 | Voltage code of read slot |
| rd_freq | output | 24 | Frequency (kHz) of read slot |
| lk_fid | input | 8 | Frequency code to search for |
| lk_vid | input | 8 | Voltage code to search for |
| lk_hit | output | 1 | A matching slot exists |
| lk_idx | output | 4 | Index of first matching slot |
| lk_freq | output | 24 | Frequency of first matching slot |

## Verification
If the insertion pointer or a comparison goes wrong, entries show up out of order or duplicated on the read port as soon as the insertion ends. That same fault also stretches or shortens the `in_ready` low window for that entry. A mistaken drop decision shows up at once as a `state_count` that is off by one. A fault in multiplier decode is first seen as a wrong `rd_freq` value, and later as a wrong position in the table. The scoreboard rebuilds the expected table after every build and compares each slot, so any of these faults shows up before the next build starts.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int BYTE_W = 8;
    localparam int FSB_W  = 8;
    localparam int MULT_W = 9;
    localparam int FREQ_W = MULT_W + 7 + FSB_W;
    localparam logic [FREQ_W-1:0] FREQ_UNKNOWN = '1;

    typedef struct packed {
        logic [BYTE_W-1:0] fid;
        logic [BYTE_W-1:0] vid;
        logic [FREQ_W-1:0] freq;
    } slot_t;

    typedef enum logic [1:0] {
        PH_FID   = 2'd0,
        PH_VID   = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;

    function automatic logic [MULT_W-1:0] mult_narrow(input logic [4:0] code);
        logic [MULT_W-1:0] m;
        if (code < 5'd4)
            m = MULT_W'(110 + 5 * int'(code));
        else if (code < 5'd16)
            m = MULT_W'(50 + 5 * (int'(code) - 4));
        else begin
            case (code)
                5'd16: m = 9'd30;
                5'd17: m = 9'd190;
                5'd18: m = 9'd40;
                5'd19: m = 9'd200;
                5'd20: m = 9'd130;
                5'd21: m = 9'd135;
                5'd22: m = 9'd140;
                5'd23: m = 9'd210;
                5'd24: m = 9'd150;
                5'd25: m = 9'd225;
                5'd26: m = 9'd160;
                5'd27: m = 9'd165;
                5'd28: m = 9'd170;
                5'd29: m = 9'd180;
                default: m = 9'd0;
            endcase
        end
        return m;
    endfunction

    function automatic logic [MULT_W-1:0] mult_wide(input logic [5:0] code);
        return MULT_W'(40 + 5 * int'(code));
    endfunction
endpackage

// File: rtl/pst_mult_rom.sv
module pst_mult_rom
    import pst_pkg::*;
(
    input  logic [BYTE_W-1:0] fid,
    input  logic              wide_fid,
    input  logic [FSB_W-1:0]  fsb_mhz,
    output logic [FREQ_W-1:0] freq,
    output logic              half_step
);
    logic [MULT_W-1:0] mult;

    always_comb begin
        if (wide_fid)
            mult = mult_wide(fid[5:0]);
        else
            mult = mult_narrow(fid[4:0]);
        freq      = FREQ_W'(mult) * FREQ_W'(100) * FREQ_W'(fsb_mhz);
        half_step = (mult % MULT_W'(10)) == MULT_W'(5);
    end
endmodule

// File: rtl/pst_lookup.sv
module pst_lookup
    import pst_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  slot_t             slots [SLOTS],
    input  logic [CNT_W-1:0]  count,
    input  logic [BYTE_W-1:0] key_fid,
    input  logic [BYTE_W-1:0] key_vid,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [FREQ_W-1:0] freq
);
    // Scan from the top so the lowest matching slot is the one left standing.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        freq = FREQ_UNKNOWN;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (CNT_W'(i) < count && slots[i].fid == key_fid && slots[i].vid == key_vid) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                freq = slots[i].freq;
            end
        end
    end
endmodule

// File: rtl/pstate_table.sv
module pstate_table
    import pst_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              build_start,
    input  logic              half_drop,
    input  logic              wide_fid,
    input  logic [FSB_W-1:0]  fsb_mhz,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [CNT_W-1:0]  state_count,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_fid,
    output logic [BYTE_W-1:0] rd_vid,
    output logic [FREQ_W-1:0] rd_freq,
    input  logic [BYTE_W-1:0] lk_fid,
    input  logic [BYTE_W-1:0] lk_vid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [FREQ_W-1:0] lk_freq
);
    slot_t             slot_q [SLOTS];
    slot_t             new_q;
    phase_e            phase_q;
    logic [BYTE_W-1:0] fid_q;
    logic [IDX_W-1:0]  pos_q;
    logic [CNT_W-1:0]  count_q;
    logic [FREQ_W-1:0] calc_freq;
    logic              calc_half;
    logic              keep_entry;
    logic              move_up;
    logic              rd_live;

    pst_mult_rom u_rom (
        .fid       (fid_q),
        .wide_fid  (wide_fid),
        .fsb_mhz   (fsb_mhz),
        .freq      (calc_freq),
        .half_step (calc_half)
    );

    pst_lookup #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lookup (
        .slots   (slot_q),
        .count   (count_q),
        .key_fid (lk_fid),
        .key_vid (lk_vid),
        .hit     (lk_hit),
        .idx     (lk_idx),
        .freq    (lk_freq)
    );

    assign keep_entry = (count_q < CNT_W'(SLOTS)) && !(half_drop && calc_half);
    assign move_up    = (pos_q != '0) && (slot_q[pos_q - 1'b1].freq < new_q.freq);

    always_ff @(posedge clk) begin
        if (rst || build_start) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i].fid  <= '0;
                slot_q[i].vid  <= '0;
                slot_q[i].freq <= FREQ_UNKNOWN;
            end
            new_q   <= '0;
            fid_q   <= '0;
            pos_q   <= '0;
            count_q <= '0;
            phase_q <= PH_FID;
        end else begin
            case (phase_q)
                PH_FID: begin
                    if (in_valid) begin
                        fid_q   <= in_byte;
                        phase_q <= PH_VID;
                    end
                end
                PH_VID: begin
                    if (in_valid) begin
                        new_q   <= '{fid: fid_q, vid: in_byte, freq: calc_freq};
                        pos_q   <= count_q[IDX_W-1:0];
                        phase_q <= keep_entry ? PH_SHIFT : PH_FID;
                    end
                end
                default: begin
                    if (move_up) begin
                        slot_q[pos_q] <= slot_q[pos_q - 1'b1];
                        pos_q         <= pos_q - 1'b1;
                    end else begin
                        slot_q[pos_q] <= new_q;
                        count_q       <= count_q + 1'b1;
                        phase_q       <= PH_FID;
                    end
                end
            endcase
        end
    end

    assign in_ready    = (phase_q != PH_SHIFT);
    assign state_count = count_q;
    assign rd_live     = CNT_W'(rd_idx) < count_q;
    assign rd_fid      = rd_live ? slot_q[rd_idx].fid : '0;
    assign rd_vid      = rd_live ? slot_q[rd_idx].vid : '0;
    assign rd_freq     = slot_q[rd_idx].freq;
endmodule

// File: rtl/pst_table_chk.sv
module pst_table_chk
    import pst_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             build_start,
    input logic             in_ready,
    input logic [CNT_W-1:0] state_count,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input slot_t            slots [SLOTS]
);
    // R1
    empty_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        build_start |=> (state_count == '0 && in_ready));

    // R6
    count_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !build_start |=> ((state_count - $past(state_count)) <= CNT_W'(1)));

    // R8
    count_capacity_chk: assert property (@(posedge clk) disable iff (rst)
        state_count <= CNT_W'(SLOTS));

    // R9
    match_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (CNT_W'(lk_idx) < state_count));

    for (genvar g = 1; g < SLOTS; g++) begin : g_order
        // R5
        sorted_order_chk: assert property (@(posedge clk) disable iff (rst)
            (in_ready && CNT_W'(g) < state_count) |-> (slots[g-1].freq >= slots[g].freq));
    end
endmodule

bind pstate_table pst_table_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .build_start (build_start),
    .in_ready    (in_ready),
    .state_count (state_count),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .slots       (slot_q)
);

// File: tb/pstate_table_bench.sv
module pstate_table_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        build_start = 1'b0;
    logic        half_drop = 1'b0;
    logic        wide_fid = 1'b0;
    logic [7:0]  fsb_mhz = 8'd100;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'd0;
    logic [4:0]  state_count;
    logic [3:0]  rd_idx = 4'd0;
    logic [7:0]  rd_fid, rd_vid, lk_fid = 8'd0, lk_vid = 8'd0;
    logic [23:0] rd_freq, lk_freq;
    logic        lk_hit;
    logic [3:0]  lk_idx;

    int total = 0;
    int bad = 0;
    int low_cycles = 0;

    int exp_fid [16];
    int exp_vid [16];
    int exp_frq [16];
    int exp_n = 0;

    typedef struct {
        int    idx;
        int    fid;
        int    vid;
        int    freq;
        string req;
    } row_t;
    row_t sb_q [$];

    localparam int UNK = 24'hFFFFFF;

    always #2 clk = ~clk;

    pstate_table u_pstate_table (
        .clk(clk), .rst(rst), .build_start(build_start), .half_drop(half_drop),
        .wide_fid(wide_fid), .fsb_mhz(fsb_mhz), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .state_count(state_count), .rd_idx(rd_idx), .rd_fid(rd_fid),
        .rd_vid(rd_vid), .rd_freq(rd_freq), .lk_fid(lk_fid), .lk_vid(lk_vid),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_freq(lk_freq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mult(input int code, input bit wide);
        int c;
        if (wide) return 40 + 5 * (code % 64);
        c = code % 32;
        case (c)
            0: return 110;  1: return 115;  2: return 120;  3: return 125;
            16: return 30;  17: return 190; 18: return 40;  19: return 200;
            20: return 130; 21: return 135; 22: return 140; 23: return 210;
            24: return 150; 25: return 225; 26: return 160; 27: return 165;
            28: return 170; 29: return 180; 30: return 0;   31: return 0;
            default: return 50 + 5 * (c - 4);
        endcase
    endfunction

    task automatic model_clear();
        exp_n = 0;
    endtask

    task automatic model_add(input int fid, input int vid);
        int m, f, j;
        m = ref_mult(fid, wide_fid);
        if (half_drop && (m % 10) == 5) return;
        if (exp_n >= 16) return;
        f = 100 * m * int'(fsb_mhz);
        j = exp_n;
        while (j > 0 && exp_frq[j-1] < f) begin
            exp_fid[j] = exp_fid[j-1];
            exp_vid[j] = exp_vid[j-1];
            exp_frq[j] = exp_frq[j-1];
            j--;
        end
        exp_fid[j] = fid;
        exp_vid[j] = vid;
        exp_frq[j] = f;
        exp_n++;
    endtask

    task automatic send_byte(input int b);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = 8'(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Driver: sends one pair, updates the model, and measures the ready-low window.
    task automatic push_pair(input int fid, input int vid);
        send_byte(fid);
        send_byte(vid);
        model_add(fid, vid);
        low_cycles = 0;
        while (!in_ready) begin
            low_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic start_build();
        @(negedge clk);
        build_start = 1'b1;
        @(negedge clk);
        build_start = 1'b0;
        model_clear();
    endtask

    task automatic post_table(input string req);
        for (int i = 0; i < 16; i++) begin
            row_t r;
            r.idx  = i;
            r.fid  = (i < exp_n) ? exp_fid[i] : 0;
            r.vid  = (i < exp_n) ? exp_vid[i] : 0;
            r.freq = (i < exp_n) ? exp_frq[i] : UNK;
            r.req  = req;
            sb_q.push_back(r);
        end
    endtask

    // Monitor: pops expected rows and compares them with the read port.
    task automatic monitor_drain();
        while (sb_q.size() > 0) begin
            row_t r;
            r = sb_q.pop_front();
            @(negedge clk);
            rd_idx = 4'(r.idx);
            #1;
            check({r.req, " fid"},  int'(rd_fid),  r.fid);
            check({r.req, " vid"},  int'(rd_vid),  r.vid);
            check({r.req, " freq"}, int'(rd_freq), r.freq);
        end
    endtask

    task automatic check_lookup(input int fid, input int vid);
        int ei, ef, eh;
        eh = 0; ei = 0; ef = UNK;
        for (int i = exp_n - 1; i >= 0; i--)
            if (exp_fid[i] == fid && exp_vid[i] == vid) begin
                eh = 1; ei = i; ef = exp_frq[i];
            end
        @(negedge clk);
        lk_fid = 8'(fid);
        lk_vid = 8'(vid);
        #1;
        check("R9 hit",   int'(lk_hit),  eh);
        check("R9 index", int'(lk_idx),  ei);
        check("R9 freq",  int'(lk_freq), ef);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 ready", int'(in_ready), 1);
        check("R1 count", int'(state_count), 0);
        post_table("R1 reset table");
        monitor_drain();

        // R2, R3, R5, R6: narrow decode, ordering, ties, ready window
        start_build();
        push_pair(4, 1);          // 50 tenths
        check("R6 ready low first entry", low_cycles, 1);
        push_pair(0, 2);          // 110 tenths, passes 1 entry
        check("R6 ready low one shift", low_cycles, 2);
        push_pair(17, 3);         // 190 tenths, passes 2 entries
        check("R6 ready low two shifts", low_cycles, 3);
        push_pair(31, 4);         // 0
        check("R6 ready low no shift", low_cycles, 1);
        push_pair(30, 5);         // 0, tie with code 31
        push_pair(13, 6);         // 95
        push_pair(13, 7);         // 95, tie
        push_pair(9, 8);          // 75
        push_pair(25, 9);         // 225
        check("R2 count", int'(state_count), exp_n);
        post_table("R5 narrow sorted");
        monitor_drain();

        // R9: match port
        check_lookup(13, 6);
        check_lookup(13, 7);
        check_lookup(30, 5);
        check_lookup(13, 99);

        // R7: half-step drop
        start_build();
        half_drop = 1'b1;
        push_pair(1, 1);          // 115 dropped
        check("R7 dropped keeps ready", low_cycles, 0);
        check("R7 dropped not counted", int'(state_count), 0);
        push_pair(2, 2);          // 120 kept
        push_pair(5, 3);          // 55 dropped
        push_pair(21, 4);         // 135 dropped
        push_pair(18, 5);         // 40 kept
        check("R7 count", int'(state_count), 2);
        post_table("R7 drop table");
        monitor_drain();
        half_drop = 1'b0;

        // R4: wide decode
        start_build();
        wide_fid = 1'b1;
        fsb_mhz  = 8'd200;
        push_pair(63, 1);
        push_pair(0, 2);
        push_pair(32, 3);
        push_pair(8'h45, 4);      // low 6 bits = 5
        post_table("R4 wide table");
        monitor_drain();

        // R8: capacity
        start_build();
        fsb_mhz = 8'd133;
        for (int k = 0; k < 18; k++) push_pair((k * 7) % 64, k);
        check("R8 count capped", int'(state_count), 16);
        post_table("R8 full table");
        monitor_drain();

        // R1: rebuild empties the table
        start_build();
        check("R1 rebuild count", int'(state_count), 0);
        post_table("R1 rebuild table");
        monitor_drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule